// File: doc/BRIEF.md
# Multiply-Accumulate Task Controller

This block runs one computation task at a time under a start/idle/ready/done handshake. The task is a dot product of N input samples with N fixed coefficients, worked out one product per clock. A requester raises `start_i` with all N samples on `x_flat_i`. The block takes a copy of the samples and signals `ready_o` for one cycle. From then on the requester may change its inputs freely. When the sum is complete the block pulses `done_o`, and `result_o` carries the sum in that cycle.

The level of `start_i` at the clock edge that closes the ready cycle decides what happens after the current task. If `start_i` is high there, the block chains into a second task the moment the first one finishes, without returning to idle. If `start_i` is low there, the block finishes the current task and parks in idle. `result_o` keeps the last sum until the next task completes, so a late reader still sees it.

Top module: `mac_task_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `idle_o` is 1, `ready_o` and `done_o` are 0 and `result_o` is 0.
- R2: When `start_i` is high at a clock edge while the block is idle, the samples are captured at that edge. In the next cycle `idle_o` is 0 and `ready_o` is 1, for exactly one cycle.
- R3: The result is the sum over k = 0..N-1 of b[k]·x[k], modulo 2^RW, with coefficient b[k] = (37·k + 5) mod 2^CW. Sample x[k] sits at bits [k·DW +: DW] of `x_flat_i`, and all values are unsigned.
- R4: `done_o` is a one-cycle pulse that arrives N+1 cycles after the ready cycle, which is N+2 cycles after the cycle in which start was sampled. `result_o` holds the new sum in the done cycle.
- R5: Changes to `x_flat_i` after the capture edge do not affect the result of the task in progress.
- R6: If `start_i` is high at the edge that ends the ready cycle, the next task follows with no idle gap. The next samples are captured at the edge that ends the last cycle before done, and the done cycle also carries the next `ready_o`. `idle_o` stays 0 throughout.
- R7: If `start_i` is low at the edge that ends the ready cycle, `idle_o` returns to 1 in the done cycle. The block then stays idle, with no ready pulse, for as long as `start_i` stays low.
- R8: `result_o` changes only in a cycle in which `done_o` is 1.
- R9: Levels of `start_i` after the ready cycle, up to the done cycle, change neither the timing nor the value of the current task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Task request |
| x_flat_i | input | N*DW | Packed input samples, sample k at bits [k*DW +: DW] |
| idle_o | output | 1 | High when no task is in progress |
| ready_o | output | 1 | One-cycle pulse: samples captured |
| done_o | output | 1 | One-cycle pulse: `result_o` holds the new sum |
| result_o | output | RW | Last completed sum |

## Verification
The checks on pulse width, latency and the hold of the result assume a requester that keeps `start_i` high until it sees `ready_o`. They also assume it decides about chaining by the level it presents during the ready cycle. The bench drives `start_i` and `x_flat_i` only on falling edges and follows exactly that rule. It then deliberately toggles `start_i` and rewrites the samples inside a running task, to show that these later levels are ignored. Each sum is compared against a model built from the coefficient formula. The bench checks the sum in the expected done cycle and also checks that no pulse appears in the cycles around it.

// File: rtl/mac_task_pkg.sv
package mac_task_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mac_state_e;

  // Coefficient generator for tap k, truncated by the caller to its width.
  function automatic logic [31:0] coef_val(input int unsigned k);
    return 32'(k * 37 + 5);
  endfunction

endpackage

// File: rtl/mac_task_fsm.sv
module mac_task_fsm
  import mac_task_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          idle_o,
  output logic          ready_o,
  output logic          done_o,
  output logic          capture_o,
  output logic          step_o,
  output logic          finish_o,
  output logic [IW-1:0] idx_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);
  localparam int LW = $clog2(N + 3) + 1;

  mac_state_e state_q;
  logic       chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idle_o  <= 1'b1;
      ready_o <= 1'b0;
      done_o  <= 1'b0;
      chain_q <= 1'b0;
      idx_o   <= '0;
    end else begin
      ready_o <= 1'b0;
      done_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            idle_o  <= 1'b0;
            ready_o <= 1'b1;
            idx_o   <= '0;
          end
        end
        ST_RUN: begin
          if (ready_o) chain_q <= start_i;
          if (idx_o == LAST_IDX) state_q <= ST_FIN;
          else idx_o <= idx_o + 1'b1;
        end
        ST_FIN: begin
          done_o <= 1'b1;
          if (chain_q) begin
            state_q <= ST_RUN;
            ready_o <= 1'b1;
            idx_o   <= '0;
          end else begin
            state_q <= ST_IDLE;
            idle_o  <= 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          idle_o  <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    capture_o = ((state_q == ST_IDLE) && start_i) || ((state_q == ST_FIN) && chain_q);
    step_o    = (state_q == ST_RUN);
    finish_o  = (state_q == ST_FIN);
  end

  // Latency window counter used only by the checks below.
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else if (ready_o) lat_q <= LW'(1);
    else if (lat_q != {LW{1'b1}}) lat_q <= lat_q + 1'b1;
  end

  // R2
  start_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_o && start_i) |=> (ready_o && !idle_o));

  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == LW'(N + 1)));

  // R6
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> !ready_o);

endmodule

// File: rtl/mac_task_capture.sv
module mac_task_capture #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            capture_i,
  input  logic [N*DW-1:0] x_flat_i,
  input  logic [IW-1:0]   idx_i,
  output logic [DW-1:0]   x_rd_o
);

  logic [DW-1:0] xreg_q [N];

  always_ff @(posedge clk) begin
    if (capture_i) begin
      for (int k = 0; k < N; k++) xreg_q[k] <= x_flat_i[k*DW +: DW];
    end
  end

  assign x_rd_o = xreg_q[idx_i];

endmodule

// File: rtl/mac_task_datapath.sv
module mac_task_datapath
  import mac_task_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int RW = DW + CW + $clog2(N),
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic          finish_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] x_rd_i,
  output logic [RW-1:0] result_o
);

  logic [CW-1:0] coef_tab [N];
  logic [RW-1:0] acc_q;
  logic [RW-1:0] prod;

  for (genvar k = 0; k < N; k++) begin : g_coef
    assign coef_tab[k] = CW'(coef_val(k));
  end

  assign prod = RW'(x_rd_i) * RW'(coef_tab[idx_i]);

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i) acc_q <= acc_q + prod;
  end

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else if (finish_i) result_o <= acc_q;
  end

  // R3
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !step_i) |=> (acc_q == '0));

endmodule

// File: rtl/mac_task_ctrl.sv
module mac_task_ctrl #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int RW = DW + CW + $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [N*DW-1:0] x_flat_i,
  output logic            idle_o,
  output logic            ready_o,
  output logic            done_o,
  output logic [RW-1:0]   result_o
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          capture;
  logic          step;
  logic          finish;
  logic [IW-1:0] idx;
  logic [DW-1:0] x_rd;

  mac_task_fsm #(.N(N), .IW(IW)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i),
    .idle_o(idle_o), .ready_o(ready_o), .done_o(done_o),
    .capture_o(capture), .step_o(step), .finish_o(finish), .idx_o(idx)
  );

  mac_task_capture #(.N(N), .DW(DW), .IW(IW)) u_capture (
    .clk(clk), .capture_i(capture), .x_flat_i(x_flat_i),
    .idx_i(idx), .x_rd_o(x_rd)
  );

  mac_task_datapath #(.N(N), .DW(DW), .CW(CW), .RW(RW), .IW(IW)) u_datapath (
    .clk(clk), .rst(rst), .clear_i(capture), .step_i(step),
    .finish_i(finish), .idx_i(idx), .x_rd_i(x_rd), .result_o(result_o)
  );

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

endmodule

// File: tb/mac_task_ctrl_bench.sv
module mac_task_ctrl_bench;

  localparam int N  = 8;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int RW = DW + CW + $clog2(N);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic [N*DW-1:0] x_flat_i = '0;
  logic            idle_o, ready_o, done_o;
  logic [RW-1:0]   result_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mac_task_ctrl #(.N(N), .DW(DW), .CW(CW), .RW(RW)) u_mac_task_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .x_flat_i(x_flat_i),
    .idle_o(idle_o), .ready_o(ready_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [RW-1:0] ref_sum(input logic [N*DW-1:0] xf);
    logic [RW-1:0] s = '0;
    for (int k = 0; k < N; k++) begin
      s = s + RW'(xf[k*DW +: DW]) * RW'((k * 37 + 5) % (1 << CW));
    end
    return s;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 idle in reset", 64'(idle_o), 64'd1);
    chk("R1 ready in reset", 64'(ready_o), 64'd0);
    chk("R1 done in reset", 64'(done_o), 64'd0);
    chk("R1 result in reset", 64'(result_o), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", 64'(idle_o), 64'd1);
    chk("R1 result after reset", 64'(result_o), 64'd0);
  endtask

  // One task, start dropped in the ready cycle; optional disturbance (R5, R9).
  task automatic t_single(input logic [N*DW-1:0] xv, input bit wiggle);
    logic [RW-1:0] exp_y = ref_sum(xv);
    @(negedge clk);
    x_flat_i = xv;
    start_i  = 1'b1;
    @(negedge clk);
    chk("R2 ready after start", 64'(ready_o), 64'd1);
    chk("R2 idle low after start", 64'(idle_o), 64'd0);
    start_i = 1'b0;
    if (wiggle) x_flat_i = ~xv;
    for (int c = 2; c <= N + 1; c++) begin
      @(negedge clk);
      chk("R4 no early done", 64'(done_o), 64'd0);
      chk("R2 ready single pulse", 64'(ready_o), 64'd0);
      if (wiggle) begin
        start_i  = c[0];
        x_flat_i = x_flat_i ^ 64'(c * 3);
      end
    end
    start_i = 1'b0;
    @(negedge clk);
    chk("R4 done at N+2", 64'(done_o), 64'd1);
    chk(wiggle ? "R5 R9 result unaffected" : "R3 result value", 64'(result_o), 64'(exp_y));
    chk("R7 idle in done cycle", 64'(idle_o), 64'd1);
    @(negedge clk);
    chk("R4 done single pulse", 64'(done_o), 64'd0);
    chk("R8 result held", 64'(result_o), 64'(exp_y));
  endtask

  task automatic t_chain(input logic [N*DW-1:0] xa, input logic [N*DW-1:0] xb);
    logic [RW-1:0] ya = ref_sum(xa);
    logic [RW-1:0] yb = ref_sum(xb);
    @(negedge clk);
    x_flat_i = xa;
    start_i  = 1'b1;
    @(negedge clk);
    chk("R6 first ready", 64'(ready_o), 64'd1);
    for (int c = 2; c <= N + 1; c++) begin
      @(negedge clk);
      if (c == 2) x_flat_i = xb;
      chk("R6 idle low while chained", 64'(idle_o), 64'd0);
    end
    @(negedge clk);
    chk("R6 first done", 64'(done_o), 64'd1);
    chk("R6 first result", 64'(result_o), 64'(ya));
    chk("R6 second ready with done", 64'(ready_o), 64'd1);
    chk("R6 no idle gap", 64'(idle_o), 64'd0);
    start_i  = 1'b0;
    x_flat_i = '0;
    for (int c = N + 3; c <= 2 * N + 2; c++) begin
      @(negedge clk);
      chk("R4 second no early done", 64'(done_o), 64'd0);
    end
    @(negedge clk);
    chk("R6 second done", 64'(done_o), 64'd1);
    chk("R6 second result", 64'(result_o), 64'(yb));
    chk("R7 idle after chain ends", 64'(idle_o), 64'd1);
  endtask

  task automatic t_idle_hold();
    logic [RW-1:0] last = result_o;
    start_i = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      x_flat_i = 64'(c * 12345);
      chk("R7 stays idle", 64'(idle_o), 64'd1);
      chk("R7 no ready while idle", 64'(ready_o), 64'd0);
      chk("R8 result stable while idle", 64'(result_o), 64'(last));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single('0, 1'b0);
    t_single({N*DW{1'b1}}, 1'b0);
    t_single(64'h0807060504030201, 1'b0);
    t_single(64'h5AC3_19E7_00FF_7B2D, 1'b1);
    t_idle_hold();
    t_chain(64'h1122334455667788, 64'hF0E1D2C3B4A59687);
    t_idle_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule